// File: doc/BRIEF.md
# Interrupt Enable and Restart Vector Controller

This block holds the processor's maskable-interrupt enable bit and turns hardware interrupt requests into a pending indication with a 16-bit service address. Software sets or clears the enable bit with one-cycle command strobes. Every interrupt acknowledge clears the enable bit, so the service routine must turn it back on. The non-maskable request is caught on its rising edge and held until it is acknowledged. It is serviced whether or not the enable bit is set. The three maskable levels are captured only on an instruction-boundary strobe.

The block also turns a 3-bit software restart number into its target address (number times eight). It tracks a halt state, which the core enters with a halt strobe and which ends when an interrupt becomes serviceable.

Top module: `irqv_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `int_en`, `irq_pending` and `halted` are 0 and `irq_vector` is 0x0000.
- R2: A pulse on `en_cmd` sets `int_en` from the next cycle on. A pulse on `dis_cmd` clears it. When both are high in the same cycle, `dis_cmd` wins.
- R3: A pulse on `irq_ack` clears `int_en` in the next cycle, and it wins over `en_cmd` in the same cycle.
- R4: A rising edge on `nmi_req` makes `irq_pending` high with vector 0x0024 from the next cycle, whatever the state of `int_en`. The latched request stays until an `irq_ack` arrives while it is latched. After that, a level that stays high does not latch it again; only a new rising edge does.
- R5: `lvl_req` is captured only in cycles where `boundary` is 1. Changes on `lvl_req` in other cycles leave `irq_pending` and `irq_vector` unchanged.
- R6: A captured maskable level makes `irq_pending` high only while `int_en` is 1.
- R7: Priority and vectors are: non-maskable 0x0024, then `lvl_req[2]` 0x003C, then `lvl_req[1]` 0x0034, then `lvl_req[0]` 0x002C. `irq_vector` is 0x0000 when nothing is pending.
- R8: `rst_target` equals `rst_num` times 8 (0x0000 to 0x0038) in the same cycle, with no register in the path.
- R9: `halt_cmd` sets `halted` in the next cycle. `halted` clears in the cycle after `irq_pending` is high. A maskable level alone cannot wake the block while `int_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_cmd | input | 1 | Enable-interrupts strobe |
| dis_cmd | input | 1 | Disable-interrupts strobe |
| irq_ack | input | 1 | Interrupt acknowledge strobe |
| boundary | input | 1 | Instruction-boundary sample strobe |
| nmi_req | input | 1 | Non-maskable request |
| lvl_req | input | 3 | Maskable requests: bit0 = 5.5, bit1 = 6.5, bit2 = 7.5 |
| halt_cmd | input | 1 | Enter-halt strobe |
| rst_num | input | 3 | Software restart number |
| int_en | output | 1 | Interrupt-enable flag |
| irq_pending | output | 1 | A serviceable interrupt is present |
| irq_vector | output | 16 | Service address of the winning request |
| rst_target | output | 16 | Software restart target address |
| halted | output | 1 | Halt state |

## Verification
The assertions check the following on every cycle:
- an acknowledge or disable strobe always leaves the enable bit clear, and an enable strobe alone sets it;
- a non-maskable edge always shows up as pending with its own vector;
- a pending interrupt always ends the halt;
- whenever something is pending with the enable bit clear, the vector is the non-maskable one.

Some behaviour only the bench scenarios can show: the full priority order, that level changes between boundaries have no effect, that a held non-maskable level does not fire again, and the restart address table. Each of these is compared against a behavioural model in every cycle.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    localparam int ADDR_W_DEF   = 16;
    localparam int NUM_LVL      = 3;
    localparam int HW_BASE_DEF  = 'h24;
    localparam int HW_STEP_DEF  = 8;
    localparam int RST_STEP_DEF = 8;
endpackage

// File: rtl/irqv_enable.sv
module irqv_enable (
    input  logic clk,
    input  logic rst_n,
    input  logic en_cmd,
    input  logic dis_cmd,
    input  logic irq_ack,
    output logic ie
);
    typedef struct packed {
        logic ie;
    } en_state_t;

    en_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (irq_ack || dis_cmd) st_d.ie = 1'b0;
        else if (en_cmd)        st_d.ie = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ie = st_q.ie;

    AST_ACK_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !ie); // R3
    AST_DIS_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        dis_cmd |=> !ie); // R2
    AST_EN_SETS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_cmd && !dis_cmd && !irq_ack) |=> ie); // R2
endmodule

// File: rtl/irqv_request.sv
module irqv_request #(
    parameter int ADDR_W  = 16,
    parameter int NLVL    = 3,
    parameter int HW_BASE = 'h24,
    parameter int HW_STEP = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ie,
    input  logic              boundary,
    input  logic              nmi_req,
    input  logic [NLVL-1:0]   lvl_req,
    input  logic              irq_ack,
    output logic              pending,
    output logic [ADDR_W-1:0] vector
);
    localparam int SRC_W = $clog2(NLVL + 1);
    localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(HW_BASE);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(HW_STEP);

    typedef struct packed {
        logic            nmi_prev;
        logic            nmi_lat;
        logic [NLVL-1:0] lvl;
    } req_state_t;

    req_state_t       st_d, st_q;
    logic [SRC_W-1:0] src;
    logic             found;

    // Source index: 0 = non-maskable, i+1 = level i; higher index wins.
    always_comb begin
        src   = '0;
        found = 1'b0;
        for (int i = 0; i < NLVL; i++) begin
            if (ie && st_q.lvl[i]) begin
                src   = SRC_W'(i + 1);
                found = 1'b1;
            end
        end
        if (st_q.nmi_lat) begin
            src   = '0;
            found = 1'b1;
        end
    end

    always_comb begin
        st_d          = st_q;
        st_d.nmi_prev = nmi_req;
        if (nmi_req && !st_q.nmi_prev)   st_d.nmi_lat = 1'b1;
        else if (irq_ack && st_q.nmi_lat) st_d.nmi_lat = 1'b0;
        if (boundary) st_d.lvl = lvl_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pending = found;
    assign vector  = found ? BASE_V + ADDR_W'(src) * STEP_V : '0;

    AST_NMI_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req && !st_q.nmi_prev) |=> (pending && vector == BASE_V)); // R4
endmodule

// File: rtl/irqv_halt.sv
module irqv_halt (
    input  logic clk,
    input  logic rst_n,
    input  logic halt_cmd,
    input  logic wake,
    output logic halted
);
    typedef struct packed {
        logic halted;
    } halt_state_t;

    halt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wake)          st_d.halted = 1'b0;
        else if (halt_cmd) st_d.halted = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign halted = st_q.halted;

    AST_WAKE_ON_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !halted); // R9
    AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_cmd && !wake) |=> halted); // R9
endmodule

// File: rtl/irqv_ctrl.sv
module irqv_ctrl
    import irqv_pkg::*;
#(
    parameter int ADDR_W   = ADDR_W_DEF,
    parameter int HW_BASE  = HW_BASE_DEF,
    parameter int HW_STEP  = HW_STEP_DEF,
    parameter int RST_STEP = RST_STEP_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_cmd,
    input  logic              dis_cmd,
    input  logic              irq_ack,
    input  logic              boundary,
    input  logic              nmi_req,
    input  logic [2:0]        lvl_req,
    input  logic              halt_cmd,
    input  logic [2:0]        rst_num,
    output logic              int_en,
    output logic              irq_pending,
    output logic [ADDR_W-1:0] irq_vector,
    output logic [ADDR_W-1:0] rst_target,
    output logic              halted
);
    localparam logic [ADDR_W-1:0] NMI_VEC = ADDR_W'(HW_BASE);

    logic ie_w, pend_w;

    irqv_enable u_enable (
        .clk(clk), .rst_n(rst_n), .en_cmd(en_cmd), .dis_cmd(dis_cmd),
        .irq_ack(irq_ack), .ie(ie_w)
    );

    irqv_request #(
        .ADDR_W(ADDR_W), .NLVL(NUM_LVL), .HW_BASE(HW_BASE), .HW_STEP(HW_STEP)
    ) u_request (
        .clk(clk), .rst_n(rst_n), .ie(ie_w), .boundary(boundary),
        .nmi_req(nmi_req), .lvl_req(lvl_req), .irq_ack(irq_ack),
        .pending(pend_w), .vector(irq_vector)
    );

    irqv_halt u_halt (
        .clk(clk), .rst_n(rst_n), .halt_cmd(halt_cmd), .wake(pend_w),
        .halted(halted)
    );

    assign int_en      = ie_w;
    assign irq_pending = pend_w;
    assign rst_target  = ADDR_W'(rst_num) * ADDR_W'(RST_STEP);

    AST_MASKED_ONLY_NMI: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pending && !int_en) |-> irq_vector == NMI_VEC); // R6
endmodule

// File: tb/irqv_ctrl_tb.sv
module irqv_ctrl_tb;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_cmd = 0, dis_cmd = 0, irq_ack = 0, boundary = 0, nmi_req = 0, halt_cmd = 0;
    logic [2:0] lvl_req = '0, rst_num = '0;
    logic int_en, irq_pending, halted;
    logic [15:0] irq_vector, rst_target;

    int n_chk = 0, n_fail = 0;
    bit started = 0, done = 0;

    // behavioural model state
    bit m_ie, m_prev, m_lat, m_halt;
    bit [2:0] m_lvl;

    always #(CLK_P/2) clk = ~clk;

    irqv_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .en_cmd(en_cmd), .dis_cmd(dis_cmd),
        .irq_ack(irq_ack), .boundary(boundary), .nmi_req(nmi_req),
        .lvl_req(lvl_req), .halt_cmd(halt_cmd), .rst_num(rst_num),
        .int_en(int_en), .irq_pending(irq_pending), .irq_vector(irq_vector),
        .rst_target(rst_target), .halted(halted)
    );

    function automatic bit m_pend();
        return m_lat || (m_ie && (m_lvl != 0));
    endfunction

    function automatic int m_vec();
        if (m_lat) return 'h24;
        if (m_ie && m_lvl[2]) return 'h3C;
        if (m_ie && m_lvl[1]) return 'h34;
        if (m_ie && m_lvl[0]) return 'h2C;
        return 0;
    endfunction

    always @(posedge clk) begin
        bit p, n_ie, n_lat, n_halt;
        started <= 1;
        if (!rst_n) begin
            m_ie = 0; m_prev = 0; m_lat = 0; m_halt = 0; m_lvl = 0;
        end else begin
            p      = m_pend();
            n_ie   = (irq_ack || dis_cmd) ? 0 : (en_cmd ? 1 : m_ie);
            n_lat  = (nmi_req && !m_prev) ? 1 : ((irq_ack && m_lat) ? 0 : m_lat);
            n_halt = p ? 0 : (halt_cmd ? 1 : m_halt);
            if (boundary) m_lvl = lvl_req;
            m_prev = nmi_req; m_ie = n_ie; m_lat = n_lat; m_halt = n_halt;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            check("R2/R3 int_en", int_en, m_ie);
            check("R4/R6 irq_pending", irq_pending, m_pend());
            check("R7 irq_vector", irq_vector, m_vec());
            check("R8 rst_target", rst_target, rst_num * 8);
            check("R9 halted", halted, m_halt);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic pulse_clear();
        en_cmd = 0; dis_cmd = 0; irq_ack = 0; boundary = 0; halt_cmd = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        cyc(3);
        check("R1 reset int_en", int_en, 0);
        check("R1 reset pending", irq_pending, 0);
        check("R1 reset halted", halted, 0);
        check("R1 reset vector", irq_vector, 0);
        rst_n = 1;
        cyc(1);
        check("R1 post-reset pending", irq_pending, 0);
        // R2
        en_cmd = 1; cyc(1); pulse_clear(); cyc(1);
        check("R2 enable", int_en, 1);
        en_cmd = 1; dis_cmd = 1; cyc(1); pulse_clear(); cyc(1);
        check("R2 disable wins", int_en, 0);
        en_cmd = 1; cyc(1); pulse_clear();
        // R7 priority through levels
        lvl_req = 3'b001; boundary = 1; cyc(1); pulse_clear(); cyc(1);
        check("R7 level5.5", irq_vector, 'h2C);
        lvl_req = 3'b011; boundary = 1; cyc(1); pulse_clear(); cyc(1);
        check("R7 level6.5", irq_vector, 'h34);
        lvl_req = 3'b111; boundary = 1; cyc(1); pulse_clear(); cyc(1);
        check("R7 level7.5", irq_vector, 'h3C);
        // R5 no capture between boundaries
        lvl_req = 3'b000; cyc(3);
        check("R5 held vector", irq_vector, 'h3C);
        check("R5 held pending", irq_pending, 1);
        // R3 ack, R6 masked
        irq_ack = 1; en_cmd = 1; cyc(1); pulse_clear(); cyc(1);
        check("R3 ack clears", int_en, 0);
        check("R6 masked level", irq_pending, 0);
        // R9 halt not woken by masked level
        halt_cmd = 1; cyc(1); pulse_clear(); cyc(3);
        check("R9 stays halted", halted, 1);
        en_cmd = 1; cyc(1); pulse_clear(); cyc(1);
        check("R9 pending", irq_pending, 1);
        cyc(1);
        check("R9 woken", halted, 0);
        dis_cmd = 1; lvl_req = 0; boundary = 1; cyc(1); pulse_clear();
        // R4 non-maskable with enable clear
        nmi_req = 1; cyc(2);
        check("R4 nmi pending", irq_pending, 1);
        check("R4 nmi vector", irq_vector, 'h24);
        irq_ack = 1; cyc(1); pulse_clear(); cyc(3);
        check("R4 held level no retrigger", irq_pending, 0);
        nmi_req = 0; cyc(1);
        en_cmd = 1; lvl_req = 3'b100; boundary = 1; nmi_req = 1; cyc(1); pulse_clear(); cyc(1);
        check("R7 nmi over 7.5", irq_vector, 'h24);
        nmi_req = 0;
        // R8 restart table
        for (int k = 0; k < 8; k++) begin
            rst_num = 3'(k); #1;
            check("R8 restart", rst_target, k * 8);
        end
        cyc(1);
        // random traffic compared cycle by cycle
        for (int i = 0; i < 2000; i++) begin
            en_cmd   = ($urandom % 6) == 0;
            dis_cmd  = ($urandom % 8) == 0;
            irq_ack  = ($urandom % 7) == 0;
            boundary = ($urandom % 3) == 0;
            nmi_req  = ($urandom % 5) == 0 ? ~nmi_req : nmi_req;
            halt_cmd = ($urandom % 9) == 0;
            lvl_req  = 3'($urandom);
            rst_num  = 3'($urandom);
            cyc(1);
        end
        pulse_clear();
        cyc(2);
        finish_run();
    end
endmodule